// File: doc/BRIEF.md
# Core-Valid Snoop Filter for an Inclusive Shared Cache

This block sits beside the tag array of a shared, inclusive last-level cache that serves several cores. For every cache line it keeps a small vector with one presence bit per core. A bit is set whenever that core's private caches may hold a copy of the line. When a core issues a read or a read-for-ownership, the block uses the vector to pick the smallest set of cores that must be probed. Because the shared cache includes everything held in the private caches, a shared-cache miss proves the line is nowhere on chip, so no probe goes out.

The tag array resolves hit and way outside this block and presents them alongside the request. A second port carries line updates: a core filling a line, a core dropping its copy, or the shared cache evicting a line. An eviction produces a back-invalidate to every core still marked as a holder, which keeps inclusion intact. Every accepted request produces exactly one decision beat on the snoop output, even when its target vector is empty. Every eviction also produces one beat. Fills and drops produce none.

All three flows use valid/ready handshakes. A beat on the snoop output stays unchanged while `snp_ready` is low. While that beat is blocked, no request and no eviction is accepted. Fills and drops only write presence bits, so they can be taken in any cycle. When both input ports are valid in the same cycle, the update port wins.

Top module: `sf_snoop_filter`

## Requirements
- R1: A fill (upd_op 2'b00) ORs the filling core's bit into the presence vector of line (addr[OFFSET_W +: SET_W], way), where the line number is set*WAYS+way. No other bit changes.
- R2: A request with tag_hit=0 gives a beat with snp_vec all zero and does not change the line's presence bits.
- R3: A read request (req_rfo=0) that hits gives snp_kind 2'b00 and snp_vec equal to the line's bits with the requester's bit removed. Afterwards the requester's bit is also set.
- R4: The requester's own bit is never set in a request beat's snp_vec. If only the requester holds the line, snp_vec is zero.
- R5: A read-for-ownership (req_rfo=1) that hits gives snp_kind 2'b01 and snp_vec equal to every other holder. Afterwards only the requester's bit is set.
- R6: An eviction (upd_op 2'b10) gives a beat with snp_kind 2'b10, snp_vec equal to the line's bits and snp_src equal to upd_core. Afterwards the line's bits are all clear.
- R7: A drop (upd_op 2'b01) clears only the named core's bit of the line.
- R8: snp_may_dirty is 1 exactly when the line held a single presence bit and that core is in snp_vec. With two or more holders it is 0.
- R9: While snp_valid=1 and snp_ready=0, the beat's fields hold steady, req_ready is 0 and evictions are refused. snp_addr echoes the request or eviction address.
- R10: Fills and drops are accepted in any cycle. When upd_valid=1, req_ready is 0.
- R11: After reset, every presence bit is clear and snp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle |
| req_core | input | CORE_W | Requesting core |
| req_addr | input | ADDR_W | Request byte address |
| req_rfo | input | 1 | 1 = read for ownership, 0 = read |
| tag_hit | input | 1 | Shared-cache tag lookup hit for the request |
| tag_way | input | WAY_W | Way that hit |
| upd_valid | input | 1 | Line update offered |
| upd_ready | output | 1 | Update accepted this cycle |
| upd_op | input | 2 | 00 fill, 01 drop, 10 evict |
| upd_core | input | CORE_W | Core being filled or dropped, or source tag for an eviction |
| upd_addr | input | ADDR_W | Line address of the update |
| upd_way | input | WAY_W | Way of the updated line |
| snp_valid | output | 1 | Decision beat present |
| snp_ready | input | 1 | Consumer takes the beat |
| snp_kind | output | 2 | 00 read probe, 01 ownership invalidate, 10 back-invalidate |
| snp_vec | output | NUM_CORES | Cores to probe or invalidate |
| snp_addr | output | ADDR_W | Address of the triggering operation |
| snp_src | output | CORE_W | Requester, or upd_core for an eviction |
| snp_may_dirty | output | 1 | Single holder targeted, so it may hold modified data |

## Verification
The hardest case to reach from the ports is an eviction that arrives while a request beat is stalled on the snoop output and a second request is already waiting. That situation exercises the refusal rules, the update-port priority and the ordering of presence-bit writes all together. The bench reaches it by a directed sequence. It holds `snp_ready` low, keeps a request pending, slips a fill through, and offers an eviction that must wait. It then releases the consumer and checks that the eviction drains first, with the waiting request seeing the cleared line. Random mixes over a small pool of lines build up multi-holder vectors, so single-holder and RFO collapse cases occur often.

// File: rtl/sf_pkg.sv
package sf_pkg;

  typedef enum logic [1:0] {
    UPD_FILL  = 2'b00,
    UPD_DROP  = 2'b01,
    UPD_EVICT = 2'b10
  } upd_op_e;

  typedef enum logic [1:0] {
    SNP_READ = 2'b00,
    SNP_OWN  = 2'b01,
    SNP_BACK = 2'b10
  } snp_kind_e;

endpackage

// File: rtl/sf_cv_array.sv
module sf_cv_array #(
  parameter int NUM_CORES = 4,
  parameter int LINES     = 64,
  parameter int IDX_W     = $clog2(LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [NUM_CORES-1:0] rd_bits,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [NUM_CORES-1:0] wr_bits
);

  logic [NUM_CORES-1:0] cv_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) cv_q[l] <= '0;
    end else if (wr_en) begin
      cv_q[wr_idx] <= wr_bits;
    end
  end

  assign rd_bits = cv_q[rd_idx];

endmodule

// File: rtl/sf_decide.sv
module sf_decide
  import sf_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = $clog2(NUM_CORES)
) (
  input  logic [NUM_CORES-1:0] cur_bits,
  input  logic                 is_upd,
  input  logic [1:0]           upd_op,
  input  logic [CORE_W-1:0]    upd_core,
  input  logic [CORE_W-1:0]    req_core,
  input  logic                 req_rfo,
  input  logic                 tag_hit,
  output logic                 wr_en,
  output logic [NUM_CORES-1:0] wr_bits,
  output logic                 emit,
  output logic [1:0]           kind,
  output logic [NUM_CORES-1:0] vec,
  output logic                 may_dirty
);

  logic [NUM_CORES-1:0] req_mask;
  logic [NUM_CORES-1:0] upd_mask;

  generate
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_dec
      assign req_mask[g] = (req_core == CORE_W'(g));
      assign upd_mask[g] = (upd_core == CORE_W'(g));
    end
  endgenerate

  always_comb begin
    wr_en   = 1'b0;
    wr_bits = cur_bits;
    emit    = 1'b0;
    kind    = SNP_READ;
    vec     = '0;
    if (is_upd) begin
      case (upd_op)
        UPD_FILL: begin
          wr_en   = 1'b1;
          wr_bits = cur_bits | upd_mask;
        end
        UPD_DROP: begin
          wr_en   = 1'b1;
          wr_bits = cur_bits & ~upd_mask;
        end
        UPD_EVICT: begin
          wr_en   = 1'b1;
          wr_bits = '0;
          emit    = 1'b1;
          kind    = SNP_BACK;
          vec     = cur_bits;
        end
        default: ;
      endcase
    end else begin
      emit = 1'b1;
      kind = req_rfo ? SNP_OWN : SNP_READ;
      if (tag_hit) begin
        vec     = cur_bits & ~req_mask;
        wr_en   = 1'b1;
        wr_bits = req_rfo ? req_mask : (cur_bits | req_mask);
      end
    end
  end

  assign may_dirty = emit && ($countones(cur_bits) == 1) && (vec != '0);

endmodule

// File: rtl/sf_snoop_out.sv
module sf_snoop_out #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 32,
  parameter int CORE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [1:0]           ld_kind,
  input  logic [NUM_CORES-1:0] ld_vec,
  input  logic [ADDR_W-1:0]    ld_addr,
  input  logic [CORE_W-1:0]    ld_src,
  input  logic                 ld_dirty,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [1:0]           out_kind,
  output logic [NUM_CORES-1:0] out_vec,
  output logic [ADDR_W-1:0]    out_addr,
  output logic [CORE_W-1:0]    out_src,
  output logic                 out_dirty,
  output logic                 slot_free
);

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_vec   <= '0;
      out_addr  <= '0;
      out_src   <= '0;
      out_dirty <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_kind  <= ld_kind;
      out_vec   <= ld_vec;
      out_addr  <= ld_addr;
      out_src   <= ld_src;
      out_dirty <= ld_dirty;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sf_snoop_filter.sv
module sf_snoop_filter
  import sf_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int SETS      = 16,
  parameter int WAYS      = 4,
  parameter int ADDR_W    = 32,
  parameter int OFFSET_W  = 6,
  parameter int CORE_W    = $clog2(NUM_CORES),
  parameter int WAY_W     = $clog2(WAYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [CORE_W-1:0]    req_core,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_rfo,
  input  logic                 tag_hit,
  input  logic [WAY_W-1:0]     tag_way,
  input  logic                 upd_valid,
  output logic                 upd_ready,
  input  logic [1:0]           upd_op,
  input  logic [CORE_W-1:0]    upd_core,
  input  logic [ADDR_W-1:0]    upd_addr,
  input  logic [WAY_W-1:0]     upd_way,
  output logic                 snp_valid,
  input  logic                 snp_ready,
  output logic [1:0]           snp_kind,
  output logic [NUM_CORES-1:0] snp_vec,
  output logic [ADDR_W-1:0]    snp_addr,
  output logic [CORE_W-1:0]    snp_src,
  output logic                 snp_may_dirty
);

  localparam int SET_W  = $clog2(SETS);
  localparam int LINES  = SETS * WAYS;
  localparam int LINE_W = SET_W + WAY_W;

  logic                 slot_free;
  logic                 upd_fire, req_fire, any_fire;
  logic [LINE_W-1:0]    line_idx;
  logic [NUM_CORES-1:0] cur_bits;
  logic                 dec_wr, dec_emit, dec_dirty;
  logic [NUM_CORES-1:0] dec_bits, dec_vec;
  logic [1:0]           dec_kind;
  logic [ADDR_W-1:0]    ld_addr;
  logic [CORE_W-1:0]    ld_src;

  // Update port has priority; evictions need a free output slot.
  assign upd_ready = upd_valid && ((upd_op != UPD_EVICT) || slot_free);
  assign req_ready = slot_free && !upd_valid;
  assign upd_fire  = upd_valid && upd_ready;
  assign req_fire  = req_valid && req_ready;
  assign any_fire  = upd_fire || req_fire;

  assign line_idx = upd_valid ? {upd_addr[OFFSET_W +: SET_W], upd_way}
                              : {req_addr[OFFSET_W +: SET_W], tag_way};

  sf_cv_array #(
    .NUM_CORES (NUM_CORES),
    .LINES     (LINES),
    .IDX_W     (LINE_W)
  ) cv_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (line_idx),
    .rd_bits (cur_bits),
    .wr_en   (dec_wr && any_fire),
    .wr_idx  (line_idx),
    .wr_bits (dec_bits)
  );

  sf_decide #(
    .NUM_CORES (NUM_CORES),
    .CORE_W    (CORE_W)
  ) dec_i (
    .cur_bits  (cur_bits),
    .is_upd    (upd_valid),
    .upd_op    (upd_op),
    .upd_core  (upd_core),
    .req_core  (req_core),
    .req_rfo   (req_rfo),
    .tag_hit   (tag_hit),
    .wr_en     (dec_wr),
    .wr_bits   (dec_bits),
    .emit      (dec_emit),
    .kind      (dec_kind),
    .vec       (dec_vec),
    .may_dirty (dec_dirty)
  );

  assign ld_addr = upd_valid ? upd_addr : req_addr;
  assign ld_src  = upd_valid ? upd_core : req_core;

  sf_snoop_out #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W),
    .CORE_W    (CORE_W)
  ) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (dec_emit && any_fire),
    .ld_kind   (dec_kind),
    .ld_vec    (dec_vec),
    .ld_addr   (ld_addr),
    .ld_src    (ld_src),
    .ld_dirty  (dec_dirty),
    .out_ready (snp_ready),
    .out_valid (snp_valid),
    .out_kind  (snp_kind),
    .out_vec   (snp_vec),
    .out_addr  (snp_addr),
    .out_src   (snp_src),
    .out_dirty (snp_may_dirty),
    .slot_free (slot_free)
  );

endmodule

// File: rtl/sf_snoop_filter_chk.sv
module sf_snoop_filter_chk #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 32,
  parameter int CORE_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_rfo,
  input logic                 tag_hit,
  input logic                 upd_valid,
  input logic                 upd_ready,
  input logic [1:0]           upd_op,
  input logic                 snp_valid,
  input logic                 snp_ready,
  input logic [1:0]           snp_kind,
  input logic [NUM_CORES-1:0] snp_vec,
  input logic [ADDR_W-1:0]    snp_addr,
  input logic [CORE_W-1:0]    snp_src,
  input logic                 snp_may_dirty
);

  a_r2_miss_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !tag_hit) |=> (snp_valid && snp_vec == '0));

  a_r4_no_self_probe: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_kind != 2'b10) |-> !snp_vec[snp_src]);

  a_r5_rfo_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_rfo) |=> (snp_valid && snp_kind == 2'b01));

  a_r6_evict_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready && upd_op == 2'b10) |=> (snp_valid && snp_kind == 2'b10));

  a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_may_dirty) |-> ($countones(snp_vec) == 1));

  a_r9_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_ready) |=> (snp_valid && $stable(snp_vec) &&
      $stable(snp_kind) && $stable(snp_addr) && $stable(snp_src)));

  a_r9_block_req: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_ready) |-> (!req_ready &&
      !(upd_valid && upd_op == 2'b10 && upd_ready)));

  a_r10_upd_first: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> !req_ready);

  a_r10_fill_free: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_op != 2'b10) |-> upd_ready);

endmodule

bind sf_snoop_filter sf_snoop_filter_chk #(
  .NUM_CORES (NUM_CORES),
  .ADDR_W    (ADDR_W),
  .CORE_W    (CORE_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_rfo       (req_rfo),
  .tag_hit       (tag_hit),
  .upd_valid     (upd_valid),
  .upd_ready     (upd_ready),
  .upd_op        (upd_op),
  .snp_valid     (snp_valid),
  .snp_ready     (snp_ready),
  .snp_kind      (snp_kind),
  .snp_vec       (snp_vec),
  .snp_addr      (snp_addr),
  .snp_src       (snp_src),
  .snp_may_dirty (snp_may_dirty)
);

// File: tb/sf_snoop_filter_tb.sv
`timescale 1ns/1ps
module sf_snoop_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_core = '0;
  logic [31:0] req_addr = '0;
  logic        req_rfo = 1'b0;
  logic        tag_hit = 1'b0;
  logic [1:0]  tag_way = '0;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [1:0]  upd_op = '0;
  logic [1:0]  upd_core = '0;
  logic [31:0] upd_addr = '0;
  logic [1:0]  upd_way = '0;
  logic        snp_valid;
  logic        snp_ready = 1'b1;
  logic [1:0]  snp_kind;
  logic [3:0]  snp_vec;
  logic [31:0] snp_addr;
  logic [1:0]  snp_src;
  logic        snp_may_dirty;

  int n_tests = 0;
  int n_fail  = 0;
  logic [3:0] ref_cv [64];

  always #2 clk = ~clk;

  sf_snoop_filter dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core),
    .req_addr(req_addr), .req_rfo(req_rfo), .tag_hit(tag_hit), .tag_way(tag_way),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_op(upd_op),
    .upd_core(upd_core), .upd_addr(upd_addr), .upd_way(upd_way),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_kind(snp_kind),
    .snp_vec(snp_vec), .snp_addr(snp_addr), .snp_src(snp_src),
    .snp_may_dirty(snp_may_dirty)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input int set);
    return {22'($urandom), 4'(set), 6'($urandom)};
  endfunction

  function automatic int line_of(input logic [31:0] a, input logic [1:0] w);
    return int'(a[9:6]) * 4 + int'(w);
  endfunction

  function automatic logic [3:0] exp_vec(input logic [3:0] b, input logic [1:0] c,
                                         input bit hit);
    return hit ? (b & ~(4'b1 << c)) : 4'b0;
  endfunction

  function automatic bit exp_dirty(input logic [3:0] b, input logic [3:0] v);
    return ($countones(b) == 1) && (v != 4'b0);
  endfunction

  function automatic logic [3:0] exp_next(input logic [3:0] b, input logic [1:0] c,
                                          input bit rfo, input bit hit);
    if (!hit) return b;
    return rfo ? (4'b1 << c) : (b | (4'b1 << c));
  endfunction

  task automatic check_beat(input string tag, input logic [1:0] k, input logic [3:0] v,
                            input logic [31:0] a, input logic [1:0] s, input bit d);
    chk(snp_valid == 1'b1, {tag, " valid"}, 32'(snp_valid), 32'd1);
    chk(snp_kind == k, {tag, " kind"}, 32'(snp_kind), 32'(k));
    chk(snp_vec == v, {tag, " vec"}, 32'(snp_vec), 32'(v));
    chk(snp_addr == a, {tag, " addr"}, snp_addr, a);
    chk(snp_src == s, {tag, " src"}, 32'(snp_src), 32'(s));
    chk(snp_may_dirty == d, {tag, " dirty"}, 32'(snp_may_dirty), 32'(d));
  endtask

  // Called at a negedge with snp_ready=1.
  task automatic do_req(input logic [1:0] c, input int set, input logic [1:0] w,
                        input bit rfo, input bit hit, input string tag);
    logic [31:0] a;
    logic [3:0] b, v;
    int ln;
    a = mk_addr(set);
    ln = line_of(a, w);
    b = ref_cv[ln];
    v = exp_vec(b, c, hit);
    req_core = c; req_addr = a; req_rfo = rfo; tag_hit = hit; tag_way = w;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check_beat(tag, rfo ? 2'b01 : 2'b00, v, a, c, exp_dirty(b, v));
    ref_cv[ln] = exp_next(b, c, rfo, hit);
  endtask

  task automatic do_upd(input logic [1:0] op, input logic [1:0] c, input int set,
                        input logic [1:0] w, input string tag);
    logic [31:0] a;
    logic [3:0] b;
    int ln;
    a = mk_addr(set);
    ln = line_of(a, w);
    b = ref_cv[ln];
    upd_op = op; upd_core = c; upd_addr = a; upd_way = w;
    upd_valid = 1'b1;
    #1;
    chk(upd_ready == 1'b1, {tag, " upd_ready"}, 32'(upd_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
    case (op)
      2'b00: ref_cv[ln] = b | (4'b1 << c);
      2'b01: ref_cv[ln] = b & ~(4'b1 << c);
      default: begin
        check_beat(tag, 2'b10, b, a, c, $countones(b) == 1);
        ref_cv[ln] = 4'b0;
      end
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) ref_cv[i] = 4'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(snp_valid == 1'b0, "R11 snp_valid in reset", 32'(snp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(snp_valid == 1'b0, "R11 snp_valid after reset", 32'(snp_valid), 32'd0);
    do_req(2'd0, 5, 2'd1, 1'b0, 1'b1, "R11 empty line after reset");
    do_req(2'd3, 9, 2'd3, 1'b1, 1'b1, "R11 empty line rfo");

    // R1 / R3: fills then reads on line (set 1, way 2)
    do_upd(2'b00, 2'd0, 1, 2'd2, "R1 fill c0");
    do_upd(2'b00, 2'd1, 1, 2'd2, "R1 fill c1");
    do_upd(2'b00, 2'd3, 1, 2'd2, "R1 fill c3");
    do_req(2'd2, 1, 2'd2, 1'b0, 1'b1, "R3 read by c2");
    chk(ref_cv[6] == 4'b1111, "R3 model holders", 32'(ref_cv[6]), 32'hf);
    do_req(2'd0, 1, 2'd2, 1'b0, 1'b1, "R3 read by holder c0");
    // R5: ownership collapses holders
    do_req(2'd2, 1, 2'd2, 1'b1, 1'b1, "R5 rfo by c2");
    // R4: only own bit
    do_req(2'd2, 1, 2'd2, 1'b0, 1'b1, "R4 own-only read");
    // R8: single foreign holder
    do_req(2'd1, 1, 2'd2, 1'b0, 1'b1, "R8 single holder probe");
    // R2: miss ignores set bits and leaves them
    do_req(2'd3, 1, 2'd2, 1'b0, 1'b0, "R2 miss");
    do_req(2'd3, 1, 2'd2, 1'b1, 1'b0, "R2 rfo miss");
    do_req(2'd0, 1, 2'd2, 1'b0, 1'b1, "R2 bits kept after miss");
    // R7: drop
    do_upd(2'b01, 2'd1, 1, 2'd2, "R7 drop c1");
    do_req(2'd3, 1, 2'd2, 1'b0, 1'b1, "R7 read after drop");
    // R6: eviction
    do_upd(2'b10, 2'd2, 1, 2'd2, "R6 evict");
    do_req(2'd0, 1, 2'd2, 1'b0, 1'b1, "R6 line empty after evict");
    do_upd(2'b00, 2'd1, 2, 2'd0, "R6 fill single");
    do_upd(2'b10, 2'd0, 2, 2'd0, "R6 evict single");

    // R9 / R10: back-pressure on the snoop output
    begin
      logic [31:0] ax, ay, ae;
      logic [3:0] vx, bb;
      do_upd(2'b00, 2'd2, 3, 2'd1, "R10 prep fill");
      snp_ready = 1'b0;
      ax = mk_addr(3);
      bb = ref_cv[13];
      vx = exp_vec(bb, 2'd0, 1'b1);
      req_core = 2'd0; req_addr = ax; req_rfo = 1'b0; tag_hit = 1'b1; tag_way = 2'd1;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ref_cv[13] = exp_next(bb, 2'd0, 1'b0, 1'b1);
      ay = mk_addr(3);
      req_core = 2'd1; req_addr = ay;
      #1;
      chk(req_ready == 1'b0, "R9 req blocked", 32'(req_ready), 32'd0);
      repeat (2) @(negedge clk);
      check_beat("R9 beat held", 2'b00, vx, ax, 2'd0, exp_dirty(bb, vx));
      upd_op = 2'b00; upd_core = 2'd3; upd_addr = mk_addr(3); upd_way = 2'd1;
      upd_valid = 1'b1;
      #1;
      chk(upd_ready == 1'b1, "R10 fill while blocked", 32'(upd_ready), 32'd1);
      chk(req_ready == 1'b0, "R10 req yields to update", 32'(req_ready), 32'd0);
      @(posedge clk);
      @(negedge clk);
      ref_cv[13] = ref_cv[13] | 4'b1000;
      ae = mk_addr(3);
      upd_op = 2'b10; upd_core = 2'd2; upd_addr = ae;
      #1;
      chk(upd_ready == 1'b0, "R9 evict refused", 32'(upd_ready), 32'd0);
      check_beat("R9 beat still held", 2'b00, vx, ax, 2'd0, exp_dirty(bb, vx));
      @(negedge clk);
      snp_ready = 1'b1;
      #1;
      chk(upd_ready == 1'b1, "R9 evict taken on drain", 32'(upd_ready), 32'd1);
      @(posedge clk);
      @(negedge clk);
      upd_valid = 1'b0;
      check_beat("R6 evict after stall", 2'b10, ref_cv[13], ae, 2'd2,
                 $countones(ref_cv[13]) == 1);
      ref_cv[13] = 4'b0;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check_beat("R9 waiting req sees cleared line", 2'b00, 4'b0, ay, 2'd1, 1'b0);
      ref_cv[13] = 4'b0010;
    end

    // Random mix
    for (int i = 0; i < 500; i++) begin
      int r;
      logic [1:0] c, w;
      int s;
      r = int'($urandom % 10);
      c = 2'($urandom);
      w = 2'($urandom);
      s = int'($urandom % 4);
      if (r < 6) do_req(c, s, w, 1'($urandom), ($urandom % 5) != 0, "R3/R5 random req");
      else if (r < 8) do_upd(2'b00, c, s, w, "R1 random fill");
      else if (r < 9) do_upd(2'b01, c, s, w, "R7 random drop");
      else do_upd(2'b10, c, s, w, "R6 random evict");
    end

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule